// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into a target device that is configured over a slow serial link. It drives an active-low program strobe, a configuration clock and a data line, and watches two open-drain status lines from the target: an active-low "ready for data" line and a "configuration complete" line. Both status lines are treated as pulled up and pass through a two-flop synchronizer before any decision uses them.

A host pulses `start` with a byte count and a group-reversal mode bit. The block pulses the program strobe low for a fixed time, releases it, and waits for the ready line with a bounded poll count. It then takes bytes from a valid/ready stream and shifts each one out most significant bit first, with one clock pulse per bit. When the last byte has gone it keeps pulsing the clock until the complete line reads high or a pulse budget runs out. In group-reversal mode the block gathers four bytes and emits them last-first, which turns little-endian 32-bit words into the order the target expects.

The outcome is reported as `busy`, `done`, `error` and a 3-bit cause code, all held until the next accepted start.

Top module: `sscfg_loader`

## Requirements
- R1: After reset `cfg_prog_n` is 1, `cfg_cclk` and `cfg_din` are 0, and `busy`, `done`, `error` and `s_ready` are 0.
- R2: An accepted start with legal settings drives `cfg_prog_n` low for exactly PROG_CYCLES clock cycles, then high; no configuration clock edge occurs while it is low or before the ready line is seen.
- R3: If the synchronized ready line (`cfg_init_n`) does not read 1 within INIT_POLLS cycles of the release, the block stops with `error`=1 and cause 1, sends no clock pulse and accepts no byte.
- R4: Each byte leaves bit 7 first; `cfg_din` changes only while `cfg_cclk` is low; each clock high phase lasts exactly HALF_DIV cycles and each low phase at least HALF_DIV cycles.
- R5: With group reversal off, exactly `byte_count` bytes are accepted on `s_valid`/`s_ready` and sent in arrival order.
- R6: With group reversal on, stream byte index k is sent at position k XOR 3 (order 3,2,1,0,7,6,5,4,...).
- R7: Group reversal with `src_aligned`=0 ends at once with `error`=1 and cause 3, without a program pulse and without accepting a byte.
- R8: Group reversal with `byte_count` not a multiple of 4 ends at once with `error`=1 and cause 4, without a program pulse and without accepting a byte.
- R9: After the data, extra clock pulses are sent until the synchronized complete line reads 1; the block then sets `done`=1 and cause 0. If the line is already high, no extra pulse is sent.
- R10: If the complete line never reads 1, exactly DONE_PULSES extra pulses are sent, then `error`=1 with cause 2.
- R11: `busy` is 1 from the accepted start to the end of the run; `done` and `error` are never both 1 and hold their values until the next accepted start.
- R12: A `start` pulse while `busy` is 1 is ignored: no second program pulse, and the running load completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| byte_count | input | LEN_W | Number of bitstream bytes, sampled at start |
| swap_words | input | 1 | Reverse byte order inside each 4-byte group |
| src_aligned | input | 1 | Stream start sits on a 4-byte boundary |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte present |
| s_ready | output | 1 | Block takes the stream byte this cycle |
| cfg_prog_n | output | 1 | Active-low program strobe to the target |
| cfg_cclk | output | 1 | Configuration clock to the target |
| cfg_din | output | 1 | Configuration data to the target |
| cfg_init_n | input | 1 | Target ready line (high means ready), pulled up |
| cfg_done | input | 1 | Target configuration-complete line, pulled up |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load completed |
| error | output | 1 | Last load failed |
| fail_cause | output | 3 | 0 none, 1 ready timeout, 2 complete timeout, 3 misaligned, 4 partial group |

## Verification
Random byte patterns are sent with gaps in `s_valid`, once in arrival order and once in group-reversal mode, so a wrong bit order, a dropped byte or a wrong group index each show as a different miscompare of the bytes rebuilt from the data line at clock rising edges. The extra-pulse count is measured with the complete line raised after zero and several extra pulses, and with it never raised, which separates the stop-on-complete path from the pulse budget. The ready-line timeout, the misaligned start and the partial group are each driven directly to tell the four cause codes apart, and a start pulse in the middle of a load shows whether the block restarts.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_INIT  = 3'd1,
    CAUSE_DONE  = 3'd2,
    CAUSE_ALIGN = 3'd3,
    CAUSE_PART  = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WINIT,
    ST_STREAM,
    ST_FLUSH
  } phase_e;

  // position inside a 4-byte group that is emitted at drain step k
  function automatic logic [1:0] grp_slot(input logic [1:0] k);
    return k ^ 2'b11;
  endfunction

  // a byte count whose two low bits are not zero leaves a partial group
  function automatic logic is_ragged(input logic [1:0] lsbs);
    return lsbs != 2'b00;
  endfunction

  // largest of three limits, used to size the shared timer
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sscfg_sync.sv
module sscfg_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sscfg_order.sv
module sscfg_order (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       swap,
  input  logic       want,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready
);
  import sscfg_pkg::*;

  logic [7:0] grp [4];
  logic [1:0] fptr;
  logic [1:0] dptr;
  logic       draining;

  logic fill_fire;
  logic drain_fire;

  always_comb begin
    if (swap) begin
      in_ready  = want && !draining;
      out_valid = draining;
      out_data  = grp[grp_slot(dptr)];
    end else begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_data  = in_data;
    end
  end

  assign fill_fire  = swap && in_valid && in_ready;
  assign drain_fire = swap && draining && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fptr     <= 2'd0;
      dptr     <= 2'd0;
      draining <= 1'b0;
    end else if (clear) begin
      fptr     <= 2'd0;
      dptr     <= 2'd0;
      draining <= 1'b0;
    end else begin
      if (fill_fire) begin
        fptr <= fptr + 2'd1;
        if (fptr == 2'd3) draining <= 1'b1;
      end
      if (drain_fire) begin
        dptr <= dptr + 2'd1;
        if (dptr == 2'd3) draining <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) grp[fptr] <= in_data;
  end

  // a drain only starts once four bytes have been gathered (pointer wrapped)
  AST_GROUP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draining) |-> (fptr == 2'd0 && dptr == 2'd0)); // R6

endmodule

// File: rtl/sscfg_shifter.sv
module sscfg_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       kick,
  output logic       cclk,
  output logic       din,
  output logic       idle
);

  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active;
  logic          hi;
  logic [HW-1:0] hcnt;
  logic [3:0]    left;
  logic [6:0]    rest;
  logic          half_end;
  logic          bit_end;

  assign half_end = active && (hcnt == HW'(HALF_DIV - 1));
  assign bit_end  = half_end && hi;
  assign idle     = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hi     <= 1'b0;
      hcnt   <= '0;
      left   <= 4'd0;
      rest   <= 7'd0;
      cclk   <= 1'b0;
      din    <= 1'b0;
    end else if (!active) begin
      if (load) begin
        active <= 1'b1;
        hi     <= 1'b0;
        hcnt   <= '0;
        left   <= 4'd8;
        rest   <= load_byte[6:0];
        din    <= load_byte[7];
      end else if (kick) begin
        active <= 1'b1;
        hi     <= 1'b0;
        hcnt   <= '0;
        left   <= 4'd1;
        rest   <= 7'd0;
        din    <= 1'b0;
      end
    end else if (half_end) begin
      hcnt <= '0;
      if (!hi) begin
        hi   <= 1'b1;
        cclk <= 1'b1;
      end else begin
        hi   <= 1'b0;
        cclk <= 1'b0;
        if (left == 4'd1) begin
          active <= 1'b0;
          din    <= 1'b0;
        end else begin
          left <= left - 4'd1;
          din  <= rest[6];
          rest <= {rest[5:0], 1'b0};
        end
      end
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // data may only move while the clock is low
  AST_DIN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(din) |-> !cclk); // R4

  // a bit ends with a falling clock edge
  AST_BIT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !cclk); // R4

  // the controller never asks for a data byte and a blank pulse together
  AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && kick)); // R9

endmodule

// File: rtl/sscfg_loader.sv
module sscfg_loader #(
  parameter int LEN_W       = 16,
  parameter int HALF_DIV    = 4,
  parameter int PROG_CYCLES = 1200,
  parameter int INIT_POLLS  = 100000,
  parameter int DONE_PULSES = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] byte_count,
  input  logic             swap_words,
  input  logic             src_aligned,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             cfg_prog_n,
  output logic             cfg_cclk,
  output logic             cfg_din,
  input  logic             cfg_init_n,
  input  logic             cfg_done,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [2:0]       fail_cause
);
  import sscfg_pkg::*;

  localparam int TMR_MAX = max3(PROG_CYCLES, INIT_POLLS, DONE_PULSES);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  phase_e           st;
  cause_e           cause_q;
  logic [TMR_W-1:0] tmr;
  logic [LEN_W-1:0] left;
  logic             swap_q;

  logic             init_s;
  logic             done_s;
  logic             sh_idle;
  logic [7:0]       ord_data;
  logic             ord_valid;

  // named internal events
  logic start_acc;
  logic bad_align;
  logic bad_part;
  logic want;
  logic src_ready;
  logic take;
  logic stream_end;
  logic flush_go;
  logic kick;
  logic init_seen;
  logic prog_end;
  logic init_expire;
  logic done_expire;

  sscfg_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_done, cfg_init_n}),
    .q     ({done_s, init_s})
  );

  assign start_acc   = start && (st == ST_IDLE);
  assign bad_align   = swap_words && !src_aligned;
  assign bad_part    = swap_words && is_ragged(byte_count[1:0]);
  assign want        = (st == ST_STREAM) && (left != '0);
  assign src_ready   = want && sh_idle;
  assign take        = ord_valid && src_ready;
  assign stream_end  = (st == ST_STREAM) && (left == '0) && sh_idle;
  assign flush_go    = (st == ST_FLUSH) && sh_idle;
  assign done_expire = flush_go && !done_s && (tmr == TMR_W'(DONE_PULSES));
  assign kick        = flush_go && !done_s && !done_expire;
  assign init_seen   = (st == ST_WINIT) && init_s;
  assign init_expire = (st == ST_WINIT) && !init_s && (tmr == TMR_W'(INIT_POLLS - 1));
  assign prog_end    = (st == ST_PROG) && (tmr == TMR_W'(PROG_CYCLES - 1));

  sscfg_order u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .swap      (swap_q),
    .want      (want),
    .in_data   (s_data),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .out_data  (ord_data),
    .out_valid (ord_valid),
    .out_ready (src_ready)
  );

  sscfg_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .load_byte (ord_data),
    .kick      (kick),
    .cclk      (cfg_cclk),
    .din       (cfg_din),
    .idle      (sh_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cause_q    <= CAUSE_NONE;
      tmr        <= '0;
      left       <= '0;
      swap_q     <= 1'b0;
      cfg_prog_n <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_acc) begin
            done    <= 1'b0;
            error   <= 1'b0;
            cause_q <= CAUSE_NONE;
            swap_q  <= swap_words;
            left    <= byte_count;
            tmr     <= '0;
            if (bad_align) begin
              error   <= 1'b1;
              cause_q <= CAUSE_ALIGN;
            end else if (bad_part) begin
              error   <= 1'b1;
              cause_q <= CAUSE_PART;
            end else begin
              st         <= ST_PROG;
              cfg_prog_n <= 1'b0;
              busy       <= 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (prog_end) begin
            cfg_prog_n <= 1'b1;
            tmr        <= '0;
            st         <= ST_WINIT;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_WINIT: begin
          if (init_seen) begin
            tmr <= '0;
            st  <= ST_STREAM;
          end else if (init_expire) begin
            error   <= 1'b1;
            cause_q <= CAUSE_INIT;
            busy    <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_STREAM: begin
          if (take) left <= left - LEN_W'(1);
          if (stream_end) begin
            tmr <= '0;
            st  <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (flush_go && done_s) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else if (done_expire) begin
            error   <= 1'b1;
            cause_q <= CAUSE_DONE;
            busy    <= 1'b0;
            st      <= ST_IDLE;
          end else if (kick) begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign fail_cause = cause_q;

  // while the program strobe is low the target sees no clock and no data
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (!cfg_cclk && !cfg_din)); // R2

  // no clock edge until the ready line has been seen
  AST_NO_CLK_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG || st == ST_WINIT) |-> !cfg_cclk); // R3

  // the stream is only drawn while a load runs
  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy); // R5

  // extra pulses never exceed the budget
  AST_FLUSH_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH) |-> (tmr <= TMR_W'(DONE_PULSES))); // R10

  // the two outcome flags exclude each other
  AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R11

  // a start while busy leaves the strobe alone
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cfg_prog_n) |=> cfg_prog_n); // R12

endmodule

// File: tb/test_sscfg_loader.sv
module test_sscfg_loader;

  localparam int HALF  = 3;
  localparam int PROGC = 5;
  localparam int INITP = 40;
  localparam int DONEP = 12;
  localparam int LW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [LW-1:0] byte_count;
  logic          swap_words;
  logic          src_aligned;
  logic [7:0]    s_data;
  logic          s_valid;
  logic          s_ready;
  logic          cfg_prog_n;
  logic          cfg_cclk;
  logic          cfg_din;
  logic          cfg_init_n;
  logic          cfg_done;
  logic          busy;
  logic          done;
  logic          error;
  logic [2:0]    fail_cause;

  always #10 clk = ~clk;

  sscfg_loader #(
    .LEN_W(LW), .HALF_DIV(HALF), .PROG_CYCLES(PROGC),
    .INIT_POLLS(INITP), .DONE_PULSES(DONEP)
  ) i_sscfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .swap_words(swap_words), .src_aligned(src_aligned),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_cclk(cfg_cclk), .cfg_din(cfg_din),
    .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
    .busy(busy), .done(done), .error(error), .fail_cause(fail_cause)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [7:0] mem [16];
  logic [7:0] rx  [16];
  int   rx_n, rx_bits, rise_cnt, prog_low, rel_cnt, acc_cnt, src_idx;
  int   hi_run, lo_run, min_hi, min_lo;
  logic [7:0] rx_sh;
  logic prev_cclk, init_en, done_en, src_en, fire_next, seen_rise;
  int   init_delay, done_at;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // target model and line monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
    if (!cfg_prog_n) begin
      prog_low++;
      cfg_init_n = 1'b0;
      cfg_done   = 1'b0;
      rel_cnt    = 0;
    end else begin
      rel_cnt++;
      if (init_en && rel_cnt == init_delay) cfg_init_n = 1'b1;
    end
    if (cfg_cclk) begin
      hi_run++;
      if (!prev_cclk) begin
        rise_cnt++;
        if (seen_rise && lo_run < min_lo) min_lo = lo_run;
        seen_rise = 1'b1;
        rx_sh = {rx_sh[6:0], cfg_din};
        rx_bits++;
        if (rx_bits % 8 == 0 && rx_n < 16) begin
          rx[rx_n] = rx_sh;
          rx_n++;
        end
        if (done_en && rise_cnt >= done_at) cfg_done = 1'b1;
      end
      lo_run = 0;
    end else begin
      if (prev_cclk && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
      lo_run++;
    end
    prev_cclk = cfg_cclk;
  end

  // stream source with random gaps
  always @(negedge clk) begin
    if (fire_next) begin
      src_idx++;
      acc_cnt++;
    end
    if (src_en && src_idx < 16) begin
      s_valid = ($urandom % 4) != 0;
      s_data  = mem[src_idx];
    end else begin
      s_valid = 1'b0;
    end
    #1;
    fire_next = s_valid && s_ready;
  end

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic run(input int len, input bit sw, input bit al, input bit init_ok,
                     input bit done_ok, input int extra, input bit poke, input string tag);
    int exp_cause, exp_rises, exp_prog, exp_acc, w;
    bit pre, reach;
    for (int k = 0; k < 16; k++) mem[k] = 8'($urandom);
    rx_n = 0; rx_bits = 0; rise_cnt = 0; prog_low = 0; acc_cnt = 0; src_idx = 0;
    hi_run = 0; lo_run = 0; min_hi = 1000; min_lo = 1000; seen_rise = 1'b0;
    init_en = init_ok; init_delay = 3 + int'($urandom % 5);
    done_en = done_ok; done_at = len * 8 + extra;
    byte_count = LW'(len); swap_words = sw; src_aligned = al; src_en = 1'b1;
    step();
    start = 1'b1;
    step();
    start = 1'b0;
    w = 0;
    while (busy && w < 20000) begin
      if (poke && w == 40) start = 1'b1;
      else start = 1'b0;
      step();
      w++;
    end
    start = 1'b0;
    src_en = 1'b0;
    repeat (4) step();

    pre = sw && (!al || (len % 4) != 0);
    if (sw && !al)           exp_cause = 3;
    else if (sw && len % 4)  exp_cause = 4;
    else if (!init_ok)       exp_cause = 1;
    else if (!done_ok)       exp_cause = 2;
    else                     exp_cause = 0;
    reach     = !pre && init_ok;
    exp_prog  = pre ? 0 : PROGC;
    exp_acc   = reach ? len : 0;
    exp_rises = !reach ? 0 : (done_ok ? len * 8 + extra : len * 8 + DONEP);

    chk(fail_cause == 3'(exp_cause), {tag, " R3 R7 R8 R10 cause"}, int'(fail_cause), exp_cause);
    chk(prog_low == exp_prog, {tag, " R2 R12 program strobe width"}, prog_low, exp_prog);
    chk(acc_cnt == exp_acc, {tag, " R5 bytes accepted"}, acc_cnt, exp_acc);
    chk(rise_cnt == exp_rises, {tag, " R9 R10 clock pulses"}, rise_cnt, exp_rises);
    if (reach) begin
      for (int k = 0; k < len; k++) begin
        int src;
        src = sw ? (k ^ 3) : k;
        chk(rx[k] == mem[src], {tag, " R4 R6 byte order"}, int'(rx[k]), int'(mem[src]));
      end
      if (rise_cnt > 0) begin
        chk(min_hi == HALF, {tag, " R4 clock high width"}, min_hi, HALF);
        chk(min_lo >= HALF, {tag, " R4 clock low width"}, min_lo, HALF);
      end
    end
    repeat (6) step();
    chk(done == (exp_cause == 0), {tag, " R11 done held"}, int'(done), int'(exp_cause == 0));
    chk(error == (exp_cause != 0), {tag, " R11 error held"}, int'(error), int'(exp_cause != 0));
    chk(!busy, {tag, " R11 busy released"}, int'(busy), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0F));
    rst_n = 1'b0; start = 1'b0; byte_count = '0; swap_words = 1'b0; src_aligned = 1'b1;
    s_data = 8'h00; s_valid = 1'b0; cfg_init_n = 1'b1; cfg_done = 1'b0;
    init_en = 1'b0; done_en = 1'b0; src_en = 1'b0; fire_next = 1'b0; prev_cclk = 1'b0;
    rx_n = 0; rx_bits = 0; rise_cnt = 0; prog_low = 0; rel_cnt = 0; acc_cnt = 0; src_idx = 0;
    hi_run = 0; lo_run = 0; min_hi = 1000; min_lo = 1000; seen_rise = 1'b0; rx_sh = 8'h00;
    init_delay = 4; done_at = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(cfg_prog_n == 1'b1, "R1 prog_n after reset", int'(cfg_prog_n), 1);
    chk(cfg_cclk == 1'b0 && cfg_din == 1'b0, "R1 cclk/din after reset", int'({cfg_cclk, cfg_din}), 0);
    chk({busy, done, error, s_ready} == 4'b0000, "R1 status after reset",
        int'({busy, done, error, s_ready}), 0);

    run(4,  1'b0, 1'b1, 1'b1, 1'b1, 3, 1'b0, "plain4");
    run(8,  1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b0, "swap8 R6");
    run(3,  1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0, "done_early R9");
    run(0,  1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b0, "empty R9");
    run(5,  1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b0, "partial R8");
    run(8,  1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b0, "misaligned R7");
    run(5,  1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b0, "plain_unaligned R5");
    run(4,  1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b0, "init_timeout R3");
    run(4,  1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, "done_timeout R10");
    run(6,  1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b1, "restart R12");
    run(12, 1'b1, 1'b1, 1'b1, 1'b1, 1, 1'b1, "swap_restart R12");

    for (int r = 0; r < 10; r++) begin
      bit sw;
      int len;
      sw  = 1'($urandom % 2);
      len = sw ? 4 * (1 + int'($urandom % 3)) : 1 + int'($urandom % 12);
      run(len, sw, 1'b1, 1'b1, 1'b1, int'($urandom % 5), 1'b0, "random R5 R6");
    end

    finish_run();
  end

endmodule